// File: doc/BRIEF.md
# OTG Session and Connect Tracker

This block follows the single downstream port of a dual-role USB controller and keeps its device-control status byte up to date. A port model reports device attach and detach as one-cycle strobes, together with the low-speed indication of the device being attached. Software writes the session-request and host-request bits. The block combines device presence with the session bit into a detect level and acts only when that level changes.

When detect rises, the block goes straight to host mode with VBUS reported valid. It does not step through ID-pin or VBUS sensing. It also latches the speed of the attached device into two flag bits. When detect falls, the VBUS field and the VBUS drive are removed. Three one-cycle event pulses (connect, disconnect, session request) go to a separate interrupt controller. All outputs are registered: an output change appears at the clock edge that samples the inputs causing it.

Top module: `otg_session_tracker`

## Requirements
- R1: After reset the status byte reads 0x00, `vbus_en_o` is low and all three event outputs are low.
- R2: Detect is true when a device is present and status bit 0 (session) is 1. Actions fire only when detect differs from its value in the previous cycle. A steady detect level produces no further connect pulse.
- R3: On a rising detect, `evt_connect_o` pulses for one cycle. Bit 7 (B-device) is cleared, bit 2 (host mode) is set, field [4:3] (VBUS level) becomes 3 and `vbus_en_o` goes high.
- R4: On a rising detect the speed flags are loaded. A low-speed device sets bit 5 and clears bit 6. Any other device sets bit 6 and clears bit 5.
- R5: On a falling detect, field [4:3] becomes 0 and `vbus_en_o` goes low. Host mode and the speed flags keep their values.
- R6: Every attach strobe pulses `evt_sessreq_o` once. An attach while a device is already present is handled as detach then attach: it also pulses `evt_disconnect_o`. If the session bit is 1, it runs the rising-detect actions again with the new device's speed.
- R7: A detach strobe while a device is present pulses `evt_disconnect_o`. A detach with no device present produces no event. When attach and detach arrive in the same cycle, attach wins.
- R8: A software write loads bit 0 (session) and bit 1 (host request) from data bits 0 and 1. Written data bits 7..2 have no effect on the status byte.
- R9: An attach and a session-bit write of 1 in the same cycle give exactly one connect pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_attach_i | input | 1 | One-cycle strobe: a device attaches to the port |
| dev_detach_i | input | 1 | One-cycle strobe: the device leaves the port |
| dev_lowspeed_i | input | 1 | Speed of the device attaching this cycle (1 = low speed) |
| sw_wr_i | input | 1 | Software write strobe for the status byte |
| sw_wdata_i | input | 8 | Software write data (only bits 1..0 are used) |
| devctl_o | output | 8 | Device-control status byte |
| vbus_en_o | output | 1 | VBUS drive enable |
| evt_connect_o | output | 1 | Connect event pulse |
| evt_disconnect_o | output | 1 | Disconnect event pulse |
| evt_sessreq_o | output | 1 | Session-request event pulse |

## Verification
The hardest case is an attach that replaces a device which is already present with detect held high. Detect never goes low at the ports in that case, yet disconnect, session request and a fresh connect with the new speed must all appear in one cycle. The bench reaches this case, and every other combination of prior presence, prior session, stored speed and same-cycle attach, detach and write, with an exhaustive sweep. For each case it rebuilds the prior state from reset through the ports, applies one stimulus cycle and then one idle cycle.

// File: rtl/otg_sess_pkg.sv
package otg_sess_pkg;

    localparam int DC_W      = 8;
    localparam int VB_W      = 2;
    localparam logic [VB_W-1:0] VB_VALID = '1;
    localparam logic [VB_W-1:0] VB_OFF   = '0;

    // Field order follows the bit positions software decodes (7 down to 0).
    typedef struct packed {
        logic            b_dev;    // 7
        logic            fs_dev;   // 6
        logic            ls_dev;   // 5
        logic [VB_W-1:0] vb_lvl;   // 4:3
        logic            host_md;  // 2
        logic            host_rq;  // 1
        logic            sess;     // 0
    } devctl_t;

    typedef struct packed {
        logic present;
        logic lowspd;
    } port_st_t;

    typedef struct packed {
        devctl_t dc;
        logic    vbus;
        logic    ev_conn;
        logic    ev_disc;
        logic    ev_sreq;
    } top_st_t;

endpackage

// File: rtl/otg_port_track.sv
module otg_port_track
    import otg_sess_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic attach_i,
    input  logic detach_i,
    input  logic lowspeed_i,
    output logic present_q_o,
    output logic present_nx_o,
    output logic lowspd_nx_o,
    output logic replace_o,
    output logic disc_o
);

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (attach_i) begin
            st_d.present = 1'b1;
            st_d.lowspd  = lowspeed_i;
        end else if (detach_i) begin
            st_d.present = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign present_q_o  = st_q.present;
    assign present_nx_o = st_d.present;
    assign lowspd_nx_o  = st_d.lowspd;
    assign replace_o    = attach_i & st_q.present;
    assign disc_o       = st_q.present & (attach_i | detach_i);

endmodule

// File: rtl/otg_detect_edge.sv
module otg_detect_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_nx_i,
    input  logic restart_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_nx_i;
        rise_o = level_nx_i & (~prev_q | restart_i);
        fall_o = ~level_nx_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/otg_session_tracker.sv
module otg_session_tracker
    import otg_sess_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dev_attach_i,
    input  logic            dev_detach_i,
    input  logic            dev_lowspeed_i,
    input  logic            sw_wr_i,
    input  logic [DC_W-1:0] sw_wdata_i,
    output logic [DC_W-1:0] devctl_o,
    output logic            vbus_en_o,
    output logic            evt_connect_o,
    output logic            evt_disconnect_o,
    output logic            evt_sessreq_o
);

    top_st_t st_d, st_q;

    logic present_q, present_nx, lowspd_nx, replace, disc;
    logic sess_nx, rise, fall;

    otg_port_track u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .attach_i     (dev_attach_i),
        .detach_i     (dev_detach_i),
        .lowspeed_i   (dev_lowspeed_i),
        .present_q_o  (present_q),
        .present_nx_o (present_nx),
        .lowspd_nx_o  (lowspd_nx),
        .replace_o    (replace),
        .disc_o       (disc)
    );

    assign sess_nx = sw_wr_i ? sw_wdata_i[0] : st_q.dc.sess;

    otg_detect_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_nx_i (present_nx & sess_nx),
        .restart_i  (replace),
        .rise_o     (rise),
        .fall_o     (fall)
    );

    always_comb begin
        st_d = st_q;
        st_d.dc.sess = sess_nx;
        if (sw_wr_i) st_d.dc.host_rq = sw_wdata_i[1];
        st_d.ev_conn = rise;
        st_d.ev_disc = disc;
        st_d.ev_sreq = dev_attach_i;
        if (rise) begin
            st_d.dc.b_dev   = 1'b0;
            st_d.dc.host_md = 1'b1;
            st_d.dc.vb_lvl  = VB_VALID;
            st_d.dc.ls_dev  = lowspd_nx;
            st_d.dc.fs_dev  = ~lowspd_nx;
            st_d.vbus       = 1'b1;
        end else if (fall) begin
            st_d.dc.vb_lvl  = VB_OFF;
            st_d.vbus       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign devctl_o         = st_q.dc;
    assign vbus_en_o        = st_q.vbus;
    assign evt_connect_o    = st_q.ev_conn;
    assign evt_disconnect_o = st_q.ev_disc;
    assign evt_sessreq_o    = st_q.ev_sreq;

endmodule

// File: rtl/otg_session_chk.sv
module otg_session_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] devctl,
    input logic       vbus_en,
    input logic       ev_conn,
    input logic       ev_disc,
    input logic       ev_sreq,
    input logic       attach,
    input logic       present_q
);

    AST_CONN_HOST_VBUS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_conn |-> (devctl[2] && !devctl[7] && devctl[4:3] == 2'b11 && vbus_en)); // R3
    AST_CONN_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_conn |-> (devctl[6] != devctl[5])); // R4
    AST_VBUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !vbus_en |-> (devctl[4:3] == 2'b00)); // R5
    AST_CONN_SESS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_conn |-> devctl[0]); // R2
    AST_SREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sreq |-> $past(attach)); // R6
    AST_DISC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_disc |-> $past(present_q)); // R7

endmodule

bind otg_session_tracker otg_session_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .devctl    (devctl_o),
    .vbus_en   (vbus_en_o),
    .ev_conn   (evt_connect_o),
    .ev_disc   (evt_disconnect_o),
    .ev_sreq   (evt_sessreq_o),
    .attach    (dev_attach_i),
    .present_q (present_q)
);

// File: tb/tb_otg_session_tracker.sv
module tb_otg_session_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       att = 1'b0, det = 1'b0, lsp = 1'b0, wr = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] devctl;
    logic       vbus, e_conn, e_disc, e_sreq;

    int errors = 0;
    int checks = 0;

    // reference state, derived from the requirements
    logic m_pres, m_ls, m_prev;
    logic [7:0] m_dc;
    logic m_vbus, m_conn, m_disc, m_sreq;

    always #4 clk = ~clk;

    otg_session_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .dev_attach_i(att), .dev_detach_i(det), .dev_lowspeed_i(lsp),
        .sw_wr_i(wr), .sw_wdata_i(wd),
        .devctl_o(devctl), .vbus_en_o(vbus),
        .evt_connect_o(e_conn), .evt_disconnect_o(e_disc), .evt_sessreq_o(e_sreq)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        cmp({ctx, " R3 R4 host/speed bits"}, {devctl[7:5], devctl[2]}, {m_dc[7:5], m_dc[2]});
        cmp({ctx, " R5 vbus field and pin"}, {devctl[4:3], vbus}, {m_dc[4:3], m_vbus});
        cmp({ctx, " R8 session/hostreq bits"}, devctl[1:0], m_dc[1:0]);
        cmp({ctx, " R2 connect event"}, e_conn, m_conn);
        cmp({ctx, " R7 disconnect event"}, e_disc, m_disc);
        cmp({ctx, " R6 sessreq event"}, e_sreq, m_sreq);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; att = 0; det = 0; lsp = 0; wr = 0; wd = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_pres = 0; m_ls = 0; m_prev = 0; m_dc = '0;
        m_vbus = 0; m_conn = 0; m_disc = 0; m_sreq = 0;
    endtask

    task automatic step(input logic a, input logic d, input logic l,
                        input logic w, input logic [7:0] data);
        logic rep, np, ns, dn, rise, fall;
        @(negedge clk);
        att = a; det = d; lsp = l; wr = w; wd = data;
        rep = a && m_pres;
        m_disc = m_pres && (a || d);
        m_sreq = a;
        np = a ? 1'b1 : (d ? 1'b0 : m_pres);
        if (a) m_ls = l;
        m_pres = np;
        ns = w ? data[0] : m_dc[0];
        m_dc[0] = ns;
        if (w) m_dc[1] = data[1];
        dn = np && ns;
        rise = dn && (!m_prev || rep);
        fall = !dn && m_prev;
        m_prev = dn;
        m_conn = rise;
        if (rise) begin
            m_dc[7] = 0; m_dc[2] = 1; m_dc[4:3] = 2'b11;
            m_dc[5] = m_ls; m_dc[6] = !m_ls; m_vbus = 1;
        end else if (fall) begin
            m_dc[4:3] = 2'b00; m_vbus = 0;
        end
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nconn;
        do_reset();
        #2;
        check_all("reset R1");

        // exhaustive sweep over prior state and one stimulus cycle
        for (int k = 0; k < 512; k++) begin
            logic ip, is, il, a, d, w, l;
            logic [1:0] v;
            logic [7:0] data;
            {ip, is, il, a, d, w, v, l} = 9'(k);
            data = {6'(k * 37 + 5), v};
            do_reset();
            if (ip) step(1, 0, il, 0, 8'h00);
            if (is) step(0, 0, 0, 1, 8'hfd);
            step(a, d, l, w, data);
            check_all("sweep stim");
            step(0, 0, 0, 0, 8'h00);
            check_all("sweep idle");
        end

        // R9: attach and session write together give a single connect
        do_reset();
        nconn = 0;
        step(1, 0, 1, 1, 8'h01);
        nconn += int'(e_conn);
        check_all("R9 same-cycle");
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 0, 0, 8'h00);
            nconn += int'(e_conn);
        end
        cmp("R9 connect pulse count", nconn, 1);

        // R6: replacement with session on re-runs connect with new speed
        step(1, 0, 0, 0, 8'h00);
        check_all("R6 replace");
        cmp("R6 replace fs flag", devctl[6:5], 2'b10);
        // R8: high data bits have no effect
        step(0, 0, 0, 1, 8'hfe);
        check_all("R8 mask");
        cmp("R8 high bits unchanged", devctl[7:2], m_dc[7:2]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule